// File: doc/BRIEF.md
# Clock Generator Configuration Slave (I2C Block Write / Block Read)

This block is a standard-mode I2C target that keeps the configuration bytes of a clock generator. A host writes it with a block write: slave address byte D2h, then a command byte and a count byte that are both acknowledged and thrown away, then configuration bytes that land in register 0, 1, 2 and so on. There is no register pointer. Every write starts at register 0, and a STOP may end the transfer after any whole byte. A host reads it with address byte D3h. The block answers with a byte count and then the registers in ascending order.

SCL and SDA are sampled on a fast system clock, at least 16 times the SCL rate, through two-flop synchronizers and edge detectors. SDA is driven open-drain through an output-enable that pulls the line low. The register bits are brought out directly. Register 0 also chooses where the 5-bit frequency code comes from: either strap pins that are captured once after reset, or a field inside register 0.

Top module: `clkgen_cfg_slave`

## Requirements
- R1: The block acknowledges only the address bytes D2h (write) and D3h (read). Any other address byte gets no ACK, and the block ignores the bus until the next START.
- R2: On a write, the first two bytes after the address are acknowledged and do not change any register.
- R3: Write data byte k, counted after the two dummy bytes, goes into register k, starting at k = 0. When a STOP follows any complete byte, the bytes already written stay, and registers that were not reached keep their old value.
- R4: A read returns 06h first, then registers 0 to 5 in order. While the master keeps acknowledging, the sequence starts again at register 0. A master NACK ends the slave's driving.
- R5: After reset, register 0 reads 00h and registers 1 to 5 read FFh.
- R6: When register 0 bit 3 is 0, freq_sel equals the strap_fs value captured in the first cycle after reset, and later changes to strap_fs have no effect. When bit 3 is 1, freq_sel[4:0] = {bit2, bit7, bit6, bit5, bit4} of register 0.
- R7: spread_en follows register 0 bit 1, and outs_hiz follows register 0 bit 0.
- R8: Write data bytes beyond the sixth register are still acknowledged but change no register.
- R9: A START or STOP seen in the middle of a byte abandons that byte and commits nothing from it. The block then accepts a new transfer normally.
- R10: sda_oe changes only in response to an SCL falling edge or a START/STOP condition, and it is released for every bit that the master drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| strap_fs | input | 5 | Frequency-select straps, captured once after reset |
| sda_oe | output | 1 | 1 pulls SDA low |
| freq_sel | output | 5 | Selected frequency code, bit 4 = most significant select |
| spread_en | output | 1 | Spread-spectrum enable (register 0 bit 1) |
| outs_hiz | output | 1 | Force clock outputs to high impedance (register 0 bit 0) |
| en_mask | output | 40 | Registers 5..1 concatenated, register 1 in bits 7:0 |

## Verification
The bench goes after the places where a block-write target usually slips. A design that treats the command byte as data shifts every register by one or two places, and this shows up directly in en_mask and in readback. A design that does not commit bytes as they arrive loses the earlier bytes of a transfer that stops early. A design that has an off-by-one at the sixth register either corrupts state or NACKs the extra bytes. The bench also checks the rest. The read order and the wrap after register 5 must be right, because a wrong count byte or a wrong wrap breaks readback. The strap capture is tested by changing the straps after reset, and a design that passes the straps straight through would follow the change. The field mapping of register 0 is tested, because a design that reads bits 4..0 as the code gives a wrong freq_sel. Finally, the bench aborts a byte halfway with a START and confirms that no register moves.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WDAT, S_WACK, S_RDAT, S_RACK
  } slv_state_t;

  // Frequency code: strap value unless register 0 bit 3 selects the field.
  function automatic logic [4:0] pick_freq(input logic [7:0] r0,
                                           input logic [4:0] strap);
    logic [4:0] fld;
    fld = {r0[2], r0[7:4]};
    return r0[3] ? fld : strap;
  endfunction

  // Power-on value of register idx.
  function automatic logic [7:0] reg_default(input int idx);
    return (idx == 0) ? 8'h00 : 8'hFF;
  endfunction

endpackage

// File: rtl/cfgs_sync.sv
module cfgs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic ev_rise,
  output logic ev_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_prev, sda_prev, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh   <= '1;
      sda_sh   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sh   <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh   <= {sda_sh[STAGES-2:0], sda_i};
      scl_prev <= scl_s;
      sda_prev <= sda_s;
    end
  end

  assign scl_s    = scl_sh[STAGES-1];
  assign sda_s    = sda_sh[STAGES-1];
  assign ev_rise  = scl_s & ~scl_prev;
  assign ev_fall  = ~scl_s & scl_prev;
  assign ev_start = scl_s & scl_prev & sda_prev & ~sda_s;
  assign ev_stop  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/cfgs_engine.sv
module cfgs_engine
  import cfgs_pkg::*;
#(
  parameter int          NREG    = 6,
  parameter int          DUMMY_N = 2,
  parameter logic [6:0]  ADDR7   = 7'h69,
  localparam int         IDX_W   = $clog2(NREG),
  localparam int         WP_MAX  = DUMMY_N + NREG,
  localparam int         WP_W    = $clog2(WP_MAX + 1),
  localparam int         RP_W    = $clog2(NREG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             ev_rise,
  input  logic             ev_fall,
  input  logic             ev_start,
  input  logic             ev_stop,
  input  logic [7:0]       rd_data,
  output logic [IDX_W-1:0] rd_idx,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             sda_oe,
  output slv_state_t       state
);
  localparam logic [7:0]      COUNT_BYTE = 8'(NREG);
  localparam logic [WP_W-1:0] WP_FIRST   = WP_W'(DUMMY_N);
  localparam logic [WP_W-1:0] WP_LAST    = WP_W'(WP_MAX);
  localparam logic [RP_W-1:0] RP_LAST    = RP_W'(NREG);

  logic [7:0]      sh, tx;
  logic [3:0]      cnt;
  logic            rnw, mnack;
  logic [WP_W-1:0] wpos;
  logic [RP_W-1:0] rpos, nxt_pos;
  logic            wp_data;

  // Read position 0 is the count byte, position k is register k-1.
  assign nxt_pos = (rpos == RP_LAST) ? RP_W'(1) : rpos + RP_W'(1);
  assign rd_idx  = IDX_W'(nxt_pos - RP_W'(1));
  assign wp_data = (wpos >= WP_FIRST) && (wpos < WP_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      sh      <= '0;
      tx      <= '0;
      cnt     <= '0;
      rnw     <= 1'b0;
      mnack   <= 1'b0;
      wpos    <= '0;
      rpos    <= '0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (ev_start) begin
        state  <= S_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (ev_stop) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          S_IDLE: ;
          S_ADDR: begin
            if (ev_rise && cnt < 4'd8) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (ev_fall && cnt == 4'd8) begin
              if (sh[7:1] == ADDR7) begin
                sda_oe <= 1'b1;
                rnw    <= sh[0];
                state  <= S_AACK;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          S_AACK: begin
            if (ev_fall) begin
              cnt <= '0;
              if (rnw) begin
                tx     <= COUNT_BYTE;
                sda_oe <= ~COUNT_BYTE[7];
                rpos   <= '0;
                state  <= S_RDAT;
              end else begin
                sda_oe <= 1'b0;
                wpos   <= '0;
                state  <= S_WDAT;
              end
            end
          end
          S_WDAT: begin
            if (ev_rise && cnt < 4'd8) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (ev_fall && cnt == 4'd8) begin
              sda_oe <= 1'b1;
              state  <= S_WACK;
              if (wp_data) begin
                wr_en   <= 1'b1;
                wr_idx  <= IDX_W'(wpos - WP_FIRST);
                wr_data <= sh;
              end
              if (wpos != WP_LAST) wpos <= wpos + WP_W'(1);
            end
          end
          S_WACK: begin
            if (ev_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= S_WDAT;
            end
          end
          S_RDAT: begin
            if (ev_rise) begin
              cnt <= cnt + 4'd1;
            end else if (ev_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                state  <= S_RACK;
              end else begin
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
              end
            end
          end
          S_RACK: begin
            if (ev_rise) begin
              mnack <= sda_s;
            end else if (ev_fall) begin
              if (mnack) begin
                sda_oe <= 1'b0;
                state  <= S_IDLE;
              end else begin
                rpos   <= nxt_pos;
                tx     <= rd_data;
                sda_oe <= ~rd_data[7];
                cnt    <= '0;
                state  <= S_RDAT;
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfgs_regbank.sv
module cfgs_regbank
  import cfgs_pkg::*;
#(
  parameter int  NREG  = 6,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [7:0]        rd_data,
  output logic [NREG*8-1:0] cfg_flat
);
  logic [7:0] mem [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[g] <= reg_default(g);
      else if (wr_en && wr_idx == IDX_W'(g))
        mem[g] <= wr_data;
    end
    assign cfg_flat[g*8 +: 8] = mem[g];
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/cfgs_outmap.sv
module cfgs_outmap
  import cfgs_pkg::*;
#(
  parameter int FS_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FS_W-1:0] strap_fs,
  input  logic [7:0]      reg0,
  output logic            strap_done,
  output logic [FS_W-1:0] freq_sel,
  output logic            spread_en,
  output logic            outs_hiz
);
  logic [FS_W-1:0] strap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q    <= '0;
      strap_done <= 1'b0;
    end else if (!strap_done) begin
      strap_q    <= strap_fs;
      strap_done <= 1'b1;
    end
  end

  assign freq_sel  = pick_freq(reg0, strap_q);
  assign spread_en = reg0[1];
  assign outs_hiz  = reg0[0];
endmodule

// File: rtl/clkgen_cfg_slave.sv
module clkgen_cfg_slave
  import cfgs_pkg::*;
#(
  parameter int         NREG    = 6,
  parameter int         DUMMY_N = 2,
  parameter logic [6:0] ADDR7   = 7'h69,
  parameter int         SYNC_N  = 2,
  localparam int        IDX_W   = $clog2(NREG)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic [4:0]            strap_fs,
  output logic                  sda_oe,
  output logic [4:0]            freq_sel,
  output logic                  spread_en,
  output logic                  outs_hiz,
  output logic [(NREG-1)*8-1:0] en_mask
);
  logic             sda_s, ev_rise, ev_fall, ev_start, ev_stop;
  logic             wr_en, strap_done;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0]       wr_data, rd_data;
  logic [NREG*8-1:0] cfg_flat;
  slv_state_t       eng_state;

  cfgs_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .ev_rise(ev_rise), .ev_fall(ev_fall),
    .ev_start(ev_start), .ev_stop(ev_stop)
  );

  cfgs_engine #(.NREG(NREG), .DUMMY_N(DUMMY_N), .ADDR7(ADDR7)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .ev_rise(ev_rise), .ev_fall(ev_fall), .ev_start(ev_start), .ev_stop(ev_stop),
    .rd_data(rd_data), .rd_idx(rd_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sda_oe(sda_oe), .state(eng_state)
  );

  cfgs_regbank #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .cfg_flat(cfg_flat)
  );

  cfgs_outmap #(.FS_W(5)) u_map (
    .clk(clk), .rst_n(rst_n), .strap_fs(strap_fs), .reg0(cfg_flat[7:0]),
    .strap_done(strap_done), .freq_sel(freq_sel),
    .spread_en(spread_en), .outs_hiz(outs_hiz)
  );

  assign en_mask = cfg_flat[NREG*8-1:8];
endmodule

// File: rtl/cfgs_chk.sv
module cfgs_chk
  import cfgs_pkg::*;
#(
  parameter int  NREG  = 6,
  localparam int IDX_W = $clog2(NREG)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic              ev_fall,
  input logic              ev_start,
  input logic              ev_stop,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [NREG*8-1:0] cfg_flat,
  input logic              strap_done,
  input logic [4:0]        freq_sel,
  input slv_state_t        eng_state
);
  AST_OE_ON_BUS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> ($past(ev_fall) || $past(ev_start) || $past(ev_stop))); // R10

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_oe); // R9

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_state == S_IDLE) |-> !sda_oe); // R1

  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) < NREG)); // R8

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_flat)); // R3

  AST_FREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(strap_done) && $stable(cfg_flat[7:0])) |-> $stable(freq_sel)); // R6
endmodule

bind clkgen_cfg_slave cfgs_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .ev_fall(ev_fall),
  .ev_start(ev_start), .ev_stop(ev_stop), .wr_en(wr_en), .wr_idx(wr_idx),
  .cfg_flat(cfg_flat), .strap_done(strap_done), .freq_sel(freq_sel),
  .eng_state(eng_state)
);

// File: tb/sim_clkgen_cfg_slave.sv
`timescale 1ns/1ps
module sim_clkgen_cfg_slave;
  localparam int Q = 4;   // sys clocks per quarter SCL period

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [4:0] strap_fs = 5'b10110;
  logic sda_oe, spread_en, outs_hiz;
  logic [4:0] freq_sel;
  logic [39:0] en_mask;
  wire sda_bus = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  clkgen_cfg_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .strap_fs(strap_fs), .sda_oe(sda_oe), .freq_sel(freq_sel),
    .spread_en(spread_en), .outs_hiz(outs_hiz), .en_mask(en_mask)
  );

  int n_chk = 0, n_bad = 0, rel_err = 0;
  logic [7:0] model [6];
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];
  localparam logic [4:0] STRAP_AT_RESET = 5'b10110;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  function automatic logic [4:0] exp_fs(input logic [7:0] r0);
    logic [4:0] v;
    if (r0[3] == 1'b0) return STRAP_AT_RESET;
    v[0] = r0[4]; v[1] = r0[5]; v[2] = r0[6]; v[3] = r0[7]; v[4] = r0[2];
    return v;
  endfunction

  function automatic logic [7:0] exp_rd(input int k);
    if (k == 0) return 8'h06;
    return model[(k - 1) % 6];
  endfunction

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic do_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic do_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw(); qw();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; qw(); scl_m = 1'b1; qw();
    if (b && sda_bus !== 1'b1) rel_err++;   // R10: slave must not hold SDA
    qw(); scl_m = 1'b0; qw();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); b = sda_bus; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    ack = ~a;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic last);
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
    put_bit(last);
  endtask

  // Write transaction: address byte, then n bytes from wbuf. Counts ACKs.
  task automatic wr_txn(input logic [7:0] addr, input int n,
                        output logic addr_ack, output int n_ack);
    logic a;
    n_ack = 0;
    do_start();
    send_byte(addr, addr_ack);
    if (addr_ack) begin
      for (int i = 0; i < n; i++) begin
        send_byte(wbuf[i], a);
        if (a) n_ack++;
      end
    end
    do_stop();
  endtask

  task automatic model_write(input int n);
    for (int i = 2; i < n; i++) if (i - 2 < 6) model[i - 2] = wbuf[i];
  endtask

  task automatic rd_txn(input int n, output logic addr_ack);
    do_start();
    send_byte(8'hD3, addr_ack);
    if (addr_ack)
      for (int i = 0; i < n; i++) recv_byte(rbuf[i], (i == n - 1));
    do_stop();
  endtask

  task automatic check_outs(input string tag);
    chk({tag, " R6 freq_sel"}, 64'(freq_sel), 64'(exp_fs(model[0])));
    chk({tag, " R7 spread_en"}, 64'(spread_en), 64'(model[0][1]));
    chk({tag, " R7 outs_hiz"}, 64'(outs_hiz), 64'(model[0][0]));
    chk({tag, " R3 en_mask"}, 64'(en_mask),
        64'({model[5], model[4], model[3], model[2], model[1]}));
  endtask

  task automatic check_read(input string tag, input int n);
    logic a;
    rd_txn(n, a);
    chk({tag, " R1 read address ack"}, 64'(a), 64'(1));
    for (int i = 0; i < n; i++)
      chk($sformatf("%s R4 read byte %0d", tag, i), 64'(rbuf[i]), 64'(exp_rd(i)));
  endtask

  initial begin
    logic a;
    int na;
    void'($urandom(32'h5EED1234));
    model[0] = 8'h00;
    for (int i = 1; i < 6; i++) model[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    strap_fs = 5'b01001;   // later strap changes must not matter (R6)
    repeat (4) @(negedge clk);

    // R5 defaults, R6 strap captured after reset
    chk("R5 sda_oe after reset", 64'(sda_oe), 64'(0));
    check_outs("R5 reset");

    // R1: wrong addresses are not acknowledged and change nothing
    wbuf[0] = 8'h00; wbuf[1] = 8'h00; wbuf[2] = 8'h5A;
    wr_txn(8'hA4, 3, a, na);
    chk("R1 foreign address no ack", 64'(a), 64'(0));
    wr_txn(8'hD0, 3, a, na);
    chk("R1 neighbour address no ack", 64'(a), 64'(0));
    check_outs("R1 after foreign");

    // R2: only the two dummy bytes
    wbuf[0] = 8'hFF; wbuf[1] = 8'hFF;
    wr_txn(8'hD2, 2, a, na);
    chk("R2 dummy bytes acked", 64'(na), 64'(2));
    check_outs("R2 dummies only");

    // R6/R7: register field selects frequency, spread on
    wbuf[0] = 8'h00; wbuf[1] = 8'h06; wbuf[2] = 8'hDE;
    wr_txn(8'hD2, 3, a, na); model_write(3);
    chk("R6 freq field mapping", 64'(freq_sel), 64'(5'b11101));
    check_outs("R6 field");

    // R7: tristate bit, frequency back to strap
    wbuf[2] = 8'h01;
    wr_txn(8'hD2, 3, a, na); model_write(3);
    check_outs("R7 hiz");

    // R3: partial write of three registers
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    wbuf[2] = 8'h02; wbuf[3] = 8'hA5; wbuf[4] = 8'h3C;
    wr_txn(8'hD2, 5, a, na); model_write(5);
    check_outs("R3 partial");

    // R8: ten data bytes, extra four acked and dropped
    for (int i = 0; i < 12; i++) wbuf[i] = 8'(8'h40 + i);
    wbuf[2] = 8'h48;
    wr_txn(8'hD2, 12, a, na); model_write(12);
    chk("R8 extra bytes acked", 64'(na), 64'(12));
    check_outs("R8 overflow");

    // R4: read with wrap past register 5
    check_read("R4 wrap", 9);

    // R9: START in the middle of a data byte commits nothing
    do_start();
    send_byte(8'hD2, a);
    send_byte(8'h00, a); send_byte(8'h00, a);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    do_start();
    do_stop();
    check_outs("R9 aborted byte");
    wbuf[0] = 8'h00; wbuf[1] = 8'h00; wbuf[2] = 8'h0A; wbuf[3] = 8'h77;
    wr_txn(8'hD2, 4, a, na); model_write(4);
    chk("R9 recovery ack", 64'(na), 64'(4));
    check_outs("R9 recovery");

    // Random block writes and reads
    for (int it = 0; it < 20; it++) begin
      int n;
      n = int'($urandom_range(0, 10));
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom());
      wr_txn(8'hD2, n, a, na); model_write(n);
      chk($sformatf("R3 random write %0d acks", it), 64'(na), 64'(n));
      check_outs($sformatf("R3 random %0d", it));
      if (it % 4 == 3) check_read($sformatf("R4 random %0d", it), int'($urandom_range(1, 9)));
    end

    chk("R10 SDA released for master bits", 64'(rel_err), 64'(0));
    summary();
  end
endmodule